// File: doc/BRIEF.md
# Configurable Asynchronous Serial Character Receiver

This block turns a serial RX line into parallel characters. A second clock enable, pulsing sixteen times per bit period, times the line. The line first passes through a two-flop synchronizer. A falling edge then starts a candidate character. The receiver confirms that start bit at its midpoint and takes every later bit at the middle of its own period. It fills a data register of up to eight bits, least significant bit first.

The line settings match those of the companion transmitter. A two-bit code picks the character size. Three more bits control parity: an enable, a type bit and a stick bit. With stick clear, the type bit chooses odd or even. With stick set, the type bit chooses a forced 1 or a forced 0. When a character finishes, the block raises a one-cycle valid strobe. In the same cycle it presents the right-aligned data and two error flags, one for parity and one for a bad stop bit. The surrounding logic latches these outputs in that cycle.

Top module: `uart_frame_rx`

## Requirements
- R1: While reset is held, and after it is released until the first character ends, rxValid, parityErr, frameErr and rxData are all 0.
- R2: wordLenCode values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits arrive least significant first and are presented right-aligned on rxData. Every rxData bit at or above the selected length is 0.
- R3: A low pulse that no longer holds low at the start bit's midpoint (tick 8 after the falling edge) produces no character.
- R4: With parityOn=1 and parityStick=0, the bit after the data is checked against the data. parityKind=0 expects an odd count of ones over the data plus the parity bit; parityKind=1 expects an even count. parityErr=1 reports a mismatch.
- R5: With parityOn=1 and parityStick=1, the received parity bit must be 1 when parityKind=0 and 0 when parityKind=1. Any other value sets parityErr.
- R6: With parityOn=0, no parity bit is expected: the stop bit directly follows the data, and parityErr stays 0.
- R7: Only the first stop bit is examined. If it samples low, frameErr is 1 for that character.
- R8: rxValid is high for exactly one clock per character. parityErr and frameErr can be 1 only in that cycle, and rxData changes only in that cycle.
- R9: A character with both a wrong parity bit and a low stop bit reports parityErr=1 and frameErr=1 with the same rxValid pulse.
- R10: A new character starts only on a high-to-low transition. A line that stays low after a framing error starts nothing until it has returned high and fallen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | Oversampling enable, 16 pulses per bit period |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| wordLenCode | input | 2 | Character length code: 0..3 selects 5..8 bits |
| parityOn | input | 1 | 1: a parity bit follows the data |
| parityKind | input | 1 | Parity type; see R4 and R5 |
| parityStick | input | 1 | 1: the parity bit is forced to a constant value |
| rxData | output | 8 | Received character, right-aligned, upper bits zero |
| rxValid | output | 1 | One-cycle strobe when a character is complete |
| parityErr | output | 1 | Parity mismatch, qualified by rxValid |
| frameErr | output | 1 | First stop bit sampled low, qualified by rxValid |

## Verification
The parity check and the stop-bit check finish in the same cycle, because both verdicts travel with the single completion strobe. The bench provokes the overlap by sending characters that carry a deliberately inverted parity bit and a low stop bit. A behavioural model computes both expected flags from the frame it drove. It compares them against what the block reports in the one cycle where rxValid is high, and checks every other clock that no flag appears outside that cycle.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int DATA_W  = 8;
  localparam int MIN_LEN = 5;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PARITY,
    RX_STOP
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearShift;
    logic shiftBit;
    logic takeParity;
    logic finish;
  } rxStrobes_t;

endpackage

// File: rtl/uart_rx_control.sv
module uart_rx_control
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxS,
  input  logic       fallEdge,
  input  logic [1:0] wordLenCode,
  input  logic       parityOn,
  output rxStrobes_t strobes
);

  localparam int TICK_W = $clog2(OVERSAMPLE);
  localparam int BIT_W  = $clog2(DATA_W);
  localparam logic [TICK_W-1:0] MID_TICK  = TICK_W'(OVERSAMPLE / 2 - 1);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(OVERSAMPLE - 1);

  rxState_t          state;
  logic [TICK_W-1:0] tickCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [BIT_W-1:0]  lastIdx;
  logic              midHit;
  logic              startHit;

  assign lastIdx  = BIT_W'(MIN_LEN - 1) + BIT_W'(wordLenCode);
  assign midHit   = sampleTick && (tickCnt == LAST_TICK);
  assign startHit = sampleTick && (tickCnt == MID_TICK);

  always_comb begin
    strobes            = '0;
    strobes.clearShift = (state == RX_START) && startHit;
    strobes.shiftBit   = (state == RX_DATA) && midHit;
    strobes.takeParity = (state == RX_PARITY) && midHit;
    strobes.finish     = (state == RX_STOP) && midHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= RX_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      unique case (state)
        RX_IDLE: begin
          tickCnt <= '0;
          bitCnt  <= '0;
          if (fallEdge) state <= RX_START;
        end
        RX_START: begin
          if (startHit) begin
            tickCnt <= '0;
            state   <= rxS ? RX_IDLE : RX_DATA;
          end else if (sampleTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (midHit) begin
            tickCnt <= '0;
            if (bitCnt == lastIdx) state <= parityOn ? RX_PARITY : RX_STOP;
            else bitCnt <= bitCnt + 1'b1;
          end else if (sampleTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_PARITY: begin
          if (midHit) begin
            tickCnt <= '0;
            state   <= RX_STOP;
          end else if (sampleTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (midHit) begin
            tickCnt <= '0;
            state   <= RX_IDLE;
          end else if (sampleTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_datapath.sv
module uart_rx_datapath
  import uart_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic [1:0]        wordLenCode,
  input  logic              parityOn,
  input  logic              parityKind,
  input  logic              parityStick,
  input  rxStrobes_t        strobes,
  output logic              rxS,
  output logic              fallEdge,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              parityErr,
  output logic              frameErr
);

  localparam int SHIFT_W = $clog2(DATA_W) + 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   rxPrev;
  logic [DATA_W-1:0]      shiftReg;
  logic                   parBit;
  logic [SHIFT_W-1:0]     shiftAmt;
  logic [DATA_W-1:0]      aligned;
  logic                   expectPar;
  logic                   parMismatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncChain <= '1;
      rxPrev    <= 1'b1;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], rxLine};
      rxPrev    <= syncChain[SYNC_STAGES-1];
    end
  end

  assign rxS      = syncChain[SYNC_STAGES-1];
  assign fallEdge = rxPrev && !rxS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (strobes.clearShift)    shiftReg <= '0;
      else if (strobes.shiftBit) shiftReg <= {rxS, shiftReg[DATA_W-1:1]};
      if (strobes.takeParity)    parBit <= rxS;
    end
  end

  assign shiftAmt    = SHIFT_W'(DATA_W - MIN_LEN) - SHIFT_W'(wordLenCode);
  assign aligned     = shiftReg >> shiftAmt;
  assign expectPar   = parityStick ? !parityKind
                                   : (parityKind ? ^aligned : !(^aligned));
  assign parMismatch = parBit ^ expectPar;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData    <= '0;
      rxValid   <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      rxValid   <= strobes.finish;
      parityErr <= strobes.finish && parityOn && parMismatch;
      frameErr  <= strobes.finish && !rxS;
      if (strobes.finish) rxData <= aligned;
    end
  end

endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxLine,
  input  logic [1:0] wordLenCode,
  input  logic       parityOn,
  input  logic       parityKind,
  input  logic       parityStick,
  output logic [7:0] rxData,
  output logic       rxValid,
  output logic       parityErr,
  output logic       frameErr
);

  rxStrobes_t strobes;
  logic       rxS;
  logic       fallEdge;

  uart_rx_control #(.OVERSAMPLE(OVERSAMPLE)) u_control (
    .clk         (clk),
    .rstN        (rstN),
    .sampleTick  (sampleTick),
    .rxS         (rxS),
    .fallEdge    (fallEdge),
    .wordLenCode (wordLenCode),
    .parityOn    (parityOn),
    .strobes     (strobes)
  );

  uart_rx_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .rxLine      (rxLine),
    .wordLenCode (wordLenCode),
    .parityOn    (parityOn),
    .parityKind  (parityKind),
    .parityStick (parityStick),
    .strobes     (strobes),
    .rxS         (rxS),
    .fallEdge    (fallEdge),
    .rxData      (rxData),
    .rxValid     (rxValid),
    .parityErr   (parityErr),
    .frameErr    (frameErr)
  );

endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] wordLenCode,
  input logic       parityOn,
  input logic [7:0] rxData,
  input logic       rxValid,
  input logic       parityErr,
  input logic       frameErr
);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  a_r8_flags_qualified: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr || frameErr) |-> rxValid);

  a_r8_data_held: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> $stable(rxData));

  a_r6_no_parity_error: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !parityOn) |-> !parityErr);

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> ((rxData >> (4'd5 + 4'(wordLenCode))) == 8'd0));

endmodule

bind uart_frame_rx uart_rx_checker u_rx_checker (
  .clk         (clk),
  .rstN        (rstN),
  .wordLenCode (wordLenCode),
  .parityOn    (parityOn),
  .rxData      (rxData),
  .rxValid     (rxValid),
  .parityErr   (parityErr),
  .frameErr    (frameErr)
);

// File: tb/uart_frame_rx_bench.sv
module uart_frame_rx_bench;

  localparam int BIT_CLKS = 64;   // 16 ticks x 4 clocks
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       rxLine = 1'b1;
  logic [1:0] wordLenCode = 2'd3;
  logic       parityOn = 1'b0;
  logic       parityKind = 1'b0;
  logic       parityStick = 1'b0;
  logic [7:0] rxData;
  logic       rxValid;
  logic       parityErr;
  logic       frameErr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [1:0] tickDiv = '0;
  logic prevValid = 1'b0;
  logic done = 1'b0;

  logic [9:0] expQ[$];   // {data, pe, fe}
  string      reqQ[$];
  string      curReq = "R1";

  always #2 clk = ~clk;

  uart_frame_rx u_uart_frame_rx (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .wordLenCode(wordLenCode), .parityOn(parityOn), .parityKind(parityKind),
    .parityStick(parityStick), .rxData(rxData), .rxValid(rxValid),
    .parityErr(parityErr), .frameErr(frameErr)
  );

  always_ff @(posedge clk) begin
    tickDiv    <= tickDiv + 2'd1;
    sampleTick <= (tickDiv == 2'd3);
  end

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // per-clock comparison against the queued expectations
  always @(negedge clk) begin
    if (rstN && !done) begin
      cycles++;
      if (prevValid) begin
        checks++;
        if (rxValid) begin
          errors++;
          $display("FAIL R8 valid two cycles: actual 1 expected 0");
        end
      end
      if (!rxValid && (parityErr || frameErr)) begin
        checks++; errors++;
        $display("FAIL R8 flag outside valid: actual pe=%0b fe=%0b expected 0 0",
                 parityErr, frameErr);
      end
      if (rxValid) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL %s unexpected character: actual %02h pe=%0b fe=%0b expected none",
                   curReq, rxData, parityErr, frameErr);
        end else begin
          logic [9:0] e;
          string r;
          e = expQ.pop_front();
          r = reqQ.pop_front();
          if ({rxData, parityErr, frameErr} !== e) begin
            errors++;
            $display("FAIL %s actual data=%02h pe=%0b fe=%0b expected data=%02h pe=%0b fe=%0b",
                     r, rxData, parityErr, frameErr, e[9:2], e[1], e[0]);
          end
        end
      end
      prevValid = rxValid;
      if (cycles > WATCHDOG) begin
        errors++;
        $display("FAIL R8 watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
        report();
      end
    end
  end

  task automatic driveBit(input logic v, input int clks);
    rxLine = v;
    repeat (clks) @(negedge clk);
  endtask

  // configure, queue expectation, send one frame
  task automatic sendFrame(input logic [7:0] d, input logic [1:0] code,
                           input logic pOn, input logic kind, input logic stick,
                           input logic badPar, input logic stopVal,
                           input int idleAfter, input string req);
    int n;
    logic [7:0] m;
    logic pb;
    n = 5 + int'(code);
    m = d & 8'((1 << n) - 1);
    if (stick) pb = !kind;
    else pb = kind ? 1'($countones(m) % 2) : 1'(1 - ($countones(m) % 2));
    if (badPar) pb = !pb;
    wordLenCode = code; parityOn = pOn; parityKind = kind; parityStick = stick;
    curReq = req;
    expQ.push_back({m, pOn && badPar, !stopVal});
    reqQ.push_back(req);
    driveBit(1'b0, BIT_CLKS);
    for (int i = 0; i < n; i++) driveBit(m[i], BIT_CLKS);
    if (pOn) driveBit(pb, BIT_CLKS);
    driveBit(stopVal, BIT_CLKS);
    driveBit(1'b1, idleAfter);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    checks++;
    if ({rxData, rxValid, parityErr, frameErr} !== 11'd0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual %03h expected 000",
               {rxData, rxValid, parityErr, frameErr});
    end
    rstN = 1'b1;
    repeat (40) @(negedge clk);
    checks++;
    if ({rxData, rxValid, parityErr, frameErr} !== 11'd0) begin
      errors++;
      $display("FAIL R1 idle after reset: actual %03h expected 000",
               {rxData, rxValid, parityErr, frameErr});
    end

    // R2 / R6: every length, no parity
    sendFrame(8'hFF, 2'd0, 0, 0, 0, 0, 1, 100, "R2");
    sendFrame(8'hEA, 2'd1, 0, 1, 0, 0, 1, 100, "R2");
    sendFrame(8'h55, 2'd2, 0, 0, 1, 0, 1, 100, "R6");
    sendFrame(8'hA5, 2'd3, 0, 0, 0, 0, 1, 100, "R2");
    sendFrame(8'h81, 2'd3, 0, 0, 0, 0, 1, 100, "R6");

    // R4: odd / even, good and bad
    sendFrame(8'h37, 2'd3, 1, 0, 0, 0, 1, 100, "R4");
    sendFrame(8'h37, 2'd3, 1, 1, 0, 0, 1, 100, "R4");
    sendFrame(8'h2C, 2'd1, 1, 0, 0, 1, 1, 100, "R4");
    sendFrame(8'h13, 2'd0, 1, 1, 0, 1, 1, 100, "R4");
    sendFrame(8'h00, 2'd2, 1, 0, 0, 0, 1, 100, "R4");

    // R5: stick parity forced 1 and forced 0
    sendFrame(8'h6B, 2'd3, 1, 0, 1, 0, 1, 100, "R5");
    sendFrame(8'h6B, 2'd3, 1, 1, 1, 0, 1, 100, "R5");
    sendFrame(8'h0F, 2'd2, 1, 0, 1, 1, 1, 100, "R5");
    sendFrame(8'h1E, 2'd0, 1, 1, 1, 1, 1, 100, "R5");

    // R3: short low glitch, no character expected
    curReq = "R3";
    driveBit(1'b0, 12);
    driveBit(1'b1, 4 * BIT_CLKS);

    // R7: framing error, then R9: both errors together
    sendFrame(8'hC3, 2'd3, 0, 0, 0, 0, 0, 100, "R7");
    sendFrame(8'h5A, 2'd3, 1, 1, 0, 1, 0, 100, "R9");
    sendFrame(8'h09, 2'd0, 1, 0, 1, 1, 0, 100, "R9");

    // R10: line stays low after a framing error
    sendFrame(8'h3C, 2'd3, 0, 0, 0, 0, 0, 0, "R10");
    driveBit(1'b0, 6 * BIT_CLKS);
    driveBit(1'b1, 2 * BIT_CLKS);
    sendFrame(8'h7E, 2'd3, 1, 1, 0, 0, 1, 200, "R10");

    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL %s missing characters: actual %0d pending expected 0",
               reqQ[0], expQ.size());
    end
    done = 1'b1;
    report();
  end

endmodule